// File: doc/BRIEF.md
# Pipelined SPN Block Cipher Encryptor

This block encrypts 128-bit blocks with the 32-round substitution-permutation cipher of the public Serpent specification. The rounds are fully unrolled, and a register sits after every round. A new plaintext block can enter on every clock, and each block leaves as ciphertext a fixed number of clocks later. Blocks keep their order through the pipe.

The key schedule is a separate unit. All 33 round keys arrive together on one wide parallel input, already in the standard (post-permutation) bit order. Each pipeline stage reads its own key slot combinationally, in the cycle that its block passes through that stage. If the keys change while blocks are in flight, each of those blocks is encrypted with a mix of the old and the new keys, split at the round boundary where the change happened.

Inside the block, the input is bit-permuted into the standard order. Rounds 0 to 30 each do three things in turn:
- XOR the round key.
- Apply S-box number (round mod 8) to all 32 nibbles.
- Apply the linear mixing.

Round 31 uses S-box 7 and then XORs the extra key K32 in place of the linear mixing. The inverse permutation then gives the ciphertext.

Top module: `spn_encrypt_pipe`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it is released, `out_valid` is 0. Blocks presented with `in_valid` high during reset produce no output.
- R2: A block accepted at rising edge n (with `in_valid` high before that edge) appears with `out_valid` high right after edge n+31. Each accepted block yields exactly one result, and results keep input order.
- R3: Blocks may be accepted on consecutive clocks. A back-to-back stream produces back-to-back results.
- R4: A cycle with `in_valid` low produces no result. Gaps in the input stream reappear unchanged at the output.
- R5: `out_data` equals the cipher output. The data are treated as four 32-bit words: word k is bits [32k+31:32k] of `in_data`. The bench encrypts in this word form, which needs no initial or final permutation. The hardware works in the standard nibble order, where bit 4j+k equals bit j of word k.
- R6: Round r uses S-box number r mod 8. Each of the eight 4-bit S-boxes is used in four rounds.
- R7: The last round applies S-box 7 and then XORs K32, with no linear mixing. Flipping a set of bits D in K32 alone flips the ciphertext by the word form of D.
- R8: Round r uses the value of key slot r that is present during the cycle before the edge on which stage r captures the block. A key change with blocks in flight affects only the rounds those blocks have not yet finished.
- R9: The output register loads only when stage 30 holds a valid block. With no new result, `out_data` holds its value whatever `in_data` and `round_keys` do.
- R10: Round key i occupies `round_keys[128*i+127:128*i]`, for i from 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk`; clears all valid flags |
| in_valid | input | 1 | A plaintext block is presented on `in_data` |
| in_data | input | 128 | Plaintext block |
| round_keys | input | 4224 | 33 round keys in standard bit order; key i in slot i |
| out_valid | output | 1 | `out_data` holds a new ciphertext block this cycle |
| out_data | output | 128 | Ciphertext block |

## Verification
Two things can coincide in a single clock. A new block can enter while an earlier one leaves, and a key change can land while blocks sit in different stages. The first case is provoked with long back-to-back and gapped streams; a scoreboard matches each result to its entry in order and to the exact edge count. The second is provoked by switching the whole key set in the middle of a stream. For each block, the reference model computes where the split falls from its acceptance edge and the switch edge, so the expected ciphertext mixes old and new keys round by round. A K32-only change and a quiet period with noisy inputs isolate the final key slot and the output hold.

// File: rtl/spn_pkg.sv
package spn_pkg;
  localparam int BLK_W   = 128;
  localparam int WORD_W  = 32;
  localparam int LANES   = BLK_W / WORD_W;   // words per block
  localparam int NIBBLES = BLK_W / LANES;    // 4-bit lanes per block
  localparam int ROUNDS  = 32;
  localparam int NKEYS   = ROUNDS + 1;
  localparam int NBOX    = 8;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [WORD_W-1:0] word_t;

  // Nibble n of the row is the image of input value n.
  function automatic logic [63:0] box_row(input int unsigned sel);
    case (sel)
      0: return 64'hC90724DEB56A1F83;
      1: return 64'h43D68EB1A50972CF;
      2: return 64'h25B04E1DFAC39768;
      3: return 64'hE57A421D369C8BF0;
      4: return 64'hD7E9A4526B0C38F1;
      5: return 64'h176D8E30C9A4B25F;
      6: return 64'h0A3DF19EB6485C27;
      default: return 64'h6539AC47B28E0FD1;
    endcase
  endfunction

  function automatic logic [3:0] box_apply(input int unsigned sel, input logic [3:0] v);
    logic [63:0] row;
    row = box_row(sel);
    return row[{v, 2'b00} +: 4];
  endfunction

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // Word form -> standard nibble order (initial permutation).
  function automatic blk_t to_std(input blk_t b);
    blk_t o;
    for (int j = 0; j < NIBBLES; j++)
      for (int k = 0; k < LANES; k++)
        o[LANES*j + k] = b[WORD_W*k + j];
    return o;
  endfunction

  // Standard nibble order -> word form (final permutation).
  function automatic blk_t to_word(input blk_t b);
    blk_t o;
    for (int j = 0; j < NIBBLES; j++)
      for (int k = 0; k < LANES; k++)
        o[WORD_W*k + j] = b[LANES*j + k];
    return o;
  endfunction

  // Linear mixing on the four words.
  function automatic blk_t mix_words(input blk_t b);
    word_t w0, w1, w2, w3;
    w0 = b[31:0];
    w1 = b[63:32];
    w2 = b[95:64];
    w3 = b[127:96];
    w0 = rotl(w0, 13);
    w2 = rotl(w2, 3);
    w1 = w1 ^ w0 ^ w2;
    w3 = w3 ^ w2 ^ (w0 << 3);
    w1 = rotl(w1, 1);
    w3 = rotl(w3, 7);
    w0 = w0 ^ w1 ^ w3;
    w2 = w2 ^ w3 ^ (w1 << 7);
    w0 = rotl(w0, 5);
    w2 = rotl(w2, 22);
    return {w3, w2, w1, w0};
  endfunction
endpackage

// File: rtl/spn_sbox_layer.sv
module spn_sbox_layer
  import spn_pkg::*;
#(
  parameter int BOX = 0
) (
  input  blk_t din,
  output blk_t dout
);
  for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
    assign dout[4*n +: 4] = box_apply(BOX, din[4*n +: 4]);
  end
endmodule

// File: rtl/spn_linmix.sv
module spn_linmix
  import spn_pkg::*;
(
  input  blk_t din,
  output blk_t dout
);
  // Blocks are held in standard order; the mixing is defined on words.
  assign dout = to_std(mix_words(to_word(din)));
endmodule

// File: rtl/spn_round_stage.sv
module spn_round_stage
  import spn_pkg::*;
#(
  parameter int RIDX = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prev_vld,
  input  blk_t prev_blk,
  input  blk_t rkey,
  input  blk_t post_key,
  output logic vld_q,
  output blk_t blk_q
);
  localparam int  BOX_SEL  = RIDX % NBOX;
  localparam bit  IS_FINAL = (RIDX == ROUNDS - 1);

  blk_t mixed, subbed, lin, blk_d;
  logic vld_d;

  assign mixed = prev_blk ^ rkey;

  spn_sbox_layer #(.BOX(BOX_SEL)) u_sbox (.din(mixed), .dout(subbed));

  if (IS_FINAL) begin : g_final
    assign lin = subbed;
  end else begin : g_mix
    spn_linmix u_lin (.din(subbed), .dout(lin));
  end

  always_comb begin
    vld_d = prev_vld;
    blk_d = lin ^ post_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (prev_vld) blk_q <= blk_d;
  end
endmodule

// File: rtl/spn_encrypt_pipe.sv
module spn_encrypt_pipe
  import spn_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [BLK_W-1:0]       in_data,
  input  logic [NKEYS*BLK_W-1:0] round_keys,
  output logic                   out_valid,
  output logic [BLK_W-1:0]       out_data
);
  logic [ROUNDS-1:0] stage_vld;
  blk_t              stage_blk [ROUNDS];
  blk_t              entry_blk;

  assign entry_blk = to_std(in_data);

  for (genvar r = 0; r < ROUNDS; r++) begin : g_round
    logic src_vld;
    blk_t src_blk;
    blk_t pk;

    if (r == 0) begin : g_head
      assign src_vld = in_valid;
      assign src_blk = entry_blk;
    end else begin : g_link
      assign src_vld = stage_vld[r-1];
      assign src_blk = stage_blk[r-1];
    end

    if (r == ROUNDS - 1) begin : g_tail_key
      assign pk = round_keys[BLK_W*ROUNDS +: BLK_W];
    end else begin : g_no_key
      assign pk = '0;
    end

    spn_round_stage #(.RIDX(r)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .prev_vld (src_vld),
      .prev_blk (src_blk),
      .rkey     (round_keys[BLK_W*r +: BLK_W]),
      .post_key (pk),
      .vld_q    (stage_vld[r]),
      .blk_q    (stage_blk[r])
    );
  end

  assign out_valid = stage_vld[ROUNDS-1];
  assign out_data  = to_word(stage_blk[ROUNDS-1]);
endmodule

// File: rtl/spn_encrypt_pipe_chk.sv
module spn_encrypt_pipe_chk
  import spn_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              out_valid,
  input logic [BLK_W-1:0]  out_data,
  input logic [ROUNDS-1:0] stage_vld
);
  // R2: the first stage takes the input flag one edge later
  assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stage_vld[0] == $past(in_valid));

  // R2, R4: each flag moves one stage per edge, bubbles included
  for (genvar i = 1; i < ROUNDS; i++) begin : g_chain
    assert_valid_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> stage_vld[i] == $past(stage_vld[i-1]));
  end

  // R1: nothing leaves right after reset release
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid);

  // R9: the output word only moves when a block reaches the last stage
  assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(stage_vld[ROUNDS-2])) |-> $stable(out_data));
endmodule

bind spn_encrypt_pipe spn_encrypt_pipe_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data),
  .stage_vld (stage_vld)
);

// File: tb/spn_encrypt_pipe_tb.sv
`timescale 1ns/1ps
module spn_encrypt_pipe_tb;
  localparam int NK = 33;
  localparam int BIG = 1 << 30;

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic             in_valid = 1'b0;
  logic [127:0]     in_data = '0;
  logic [NK*128-1:0] round_keys = '0;
  logic             out_valid;
  logic [127:0]     out_data;

  always #2 clk = ~clk;  // 250 MHz

  spn_encrypt_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .round_keys(round_keys), .out_valid(out_valid), .out_data(out_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [127:0] ks_a [NK];
  logic [127:0] ks_b [NK];
  int switch_edge = BIG;

  typedef struct {
    logic [127:0] exp;
    int           edge_n;
    string        req;
  } item_t;
  item_t sb[$];
  logic [127:0] last_out = '0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%032h expected=%032h", req, act, exp);
    end
  endtask

  // ---------------- reference model (word form) ----------------
  function automatic logic [63:0] ref_row(input int b);
    case (b)
      0: return 64'hC90724DEB56A1F83;
      1: return 64'h43D68EB1A50972CF;
      2: return 64'h25B04E1DFAC39768;
      3: return 64'hE57A421D369C8BF0;
      4: return 64'hD7E9A4526B0C38F1;
      5: return 64'h176D8E30C9A4B25F;
      6: return 64'h0A3DF19EB6485C27;
      default: return 64'h6539AC47B28E0FD1;
    endcase
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // standard order -> word form
  function automatic logic [127:0] slice(input logic [127:0] s);
    logic [127:0] o;
    for (int j = 0; j < 32; j++)
      for (int k = 0; k < 4; k++)
        o[32*k + j] = s[4*j + k];
    return o;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] pt, input int split);
    logic [31:0] x [4];
    logic [127:0] kw;
    logic [63:0] row;
    logic [3:0] v, o;
    for (int k = 0; k < 4; k++) x[k] = pt[32*k +: 32];
    for (int r = 0; r < 32; r++) begin
      kw = slice(r < split ? ks_a[r] : ks_b[r]);
      for (int k = 0; k < 4; k++) x[k] = x[k] ^ kw[32*k +: 32];
      row = ref_row(r % 8);                         // R6
      for (int j = 0; j < 32; j++) begin
        v = {x[3][j], x[2][j], x[1][j], x[0][j]};
        o = row[4*v +: 4];
        for (int k = 0; k < 4; k++) x[k][j] = o[k];
      end
      if (r < 31) begin
        x[0] = rl(x[0], 13); x[2] = rl(x[2], 3);
        x[1] = x[1] ^ x[0] ^ x[2];
        x[3] = x[3] ^ x[2] ^ (x[0] << 3);
        x[1] = rl(x[1], 1); x[3] = rl(x[3], 7);
        x[0] = x[0] ^ x[1] ^ x[3];
        x[2] = x[2] ^ x[3] ^ (x[1] << 7);
        x[0] = rl(x[0], 5); x[2] = rl(x[2], 22);
      end else begin                                // R7
        kw = slice(r < split ? ks_a[32] : ks_b[32]);
        for (int k = 0; k < 4; k++) x[k] = x[k] ^ kw[32*k +: 32];
      end
    end
    return {x[3], x[2], x[1], x[0]};
  endfunction

  // R10: slot i at bits [128i+127:128i]
  function automatic logic [NK*128-1:0] pack_keys(input bit use_b);
    logic [NK*128-1:0] p;
    for (int i = 0; i < NK; i++) p[128*i +: 128] = use_b ? ks_b[i] : ks_a[i];
    return p;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // ---------------- driver ----------------
  task automatic tick(input logic v, input logic [127:0] d, input string req);
    int e;
    int split;
    item_t it;
    @(negedge clk);
    e = cyc + 1;
    round_keys = pack_keys(e >= switch_edge);
    in_valid = v;
    in_data = d;
    if (v) begin
      split = (switch_edge - e > 32) ? 32 : ((switch_edge - e < 0) ? 0 : switch_edge - e);
      it.exp = ref_enc(d, split);
      it.edge_n = e;
      it.req = req;
      sb.push_back(it);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 36; i++) tick(1'b0, rnd128(), "");
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected result", out_data, '0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(out_data === it.exp, it.req, out_data, it.exp);
        chk(cyc - it.edge_n == 31, "R2 latency", 128'(cyc - it.edge_n), 128'd31);
        last_out = out_data;
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [127:0] p, o1, o2, d, snap;
    bit bad;
    for (int i = 0; i < NK; i++) begin ks_a[i] = '0; ks_b[i] = '0; end

    // R1: reset with input activity
    #1 rst_n = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = rnd128();
      if (out_valid !== 1'b0) bad = 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    chk(!bad, "R1 out_valid during reset", 128'(bad), 128'd0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      tick(1'b0, '0, "");
      if (out_valid !== 1'b0) bad = 1;
    end
    chk(!bad, "R1 no output after reset", 128'(bad), 128'd0);

    // R5: all-zero key and plaintext
    tick(1'b1, '0, "R5 zero block");
    drain();

    // R3, R5, R6: back-to-back stream with random keys
    for (int i = 0; i < NK; i++) ks_a[i] = rnd128();
    for (int i = 0; i < 40; i++) tick(1'b1, rnd128(), "R3,R5,R6 stream");
    // R4: gapped stream
    for (int i = 0; i < 45; i++) tick(i % 3 == 0, rnd128(), "R4 gapped");
    drain();

    // R9: quiet period with noisy inputs and new keys
    snap = out_data;
    bad = 0;
    for (int i = 0; i < NK; i++) ks_a[i] = rnd128();
    for (int i = 0; i < 12; i++) begin
      tick(1'b0, rnd128(), "");
      if (out_data !== snap || out_valid !== 1'b0) bad = 1;
    end
    chk(!bad, "R9 output held while idle", out_data, snap);

    // R7, R10: K32 alone changes the output by its word form
    p = rnd128();
    d = rnd128();
    tick(1'b1, p, "R7 base");
    drain();
    o1 = last_out;
    ks_a[32] = ks_a[32] ^ d;
    tick(1'b1, p, "R7 delta");
    drain();
    o2 = last_out;
    chk((o1 ^ o2) === slice(d), "R7,R10 last-key delta", o1 ^ o2, slice(d));

    // R8: full key switch with blocks in flight
    for (int i = 0; i < NK; i++) ks_b[i] = rnd128();
    switch_edge = cyc + 1 + 17;
    for (int i = 0; i < 50; i++) tick(1'b1, rnd128(), "R8 key switch mid-flight");
    drain();
    for (int i = 0; i < NK; i++) ks_a[i] = ks_b[i];
    switch_edge = BIG;

    // R3: one more dense burst after the switch
    for (int i = 0; i < 20; i++) tick(1'b1, rnd128(), "R3,R5 post-switch");
    drain();

    chk(sb.size() == 0, "R2 every block produced", 128'(sb.size()), 128'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule